// File: doc/BRIEF.md
# General Register Datapath

This block is the execute core of a small register-organised processor. It holds seven general-purpose registers. Two operand multiplexers feed a compact ALU, and a one-hot destination decoder writes the ALU result back into one register. Every clock cycle performs one micro-operation: select two operands, compute, and, when loading is enabled, capture the result.

A controller outside the block drives the three 3-bit select fields, the 4-bit operation code and the load enable each cycle. Select code 0 on either operand multiplexer routes the external input word onto that operand bus. This is how constants and data enter the register file. Destination code 0 names no register, so the operation can be evaluated and observed on the result port without changing any stored state.

The result and the four status flags are combinational from the current register contents and the inputs. Register updates occur only at the rising clock edge, under a synchronous active-low reset.

Top module: `gp_reg_datapath`

## Requirements
- R1: While reset is low at a clock edge, all seven registers become zero, even if a load is requested in the same cycle.
- R2: Operand A is the external input word when its select is 0, and register Rk when its select is k (1 to 7).
- R3: Operand B follows the same selection rule as operand A, using its own select field.
- R4: With load high and destination code k in 1 to 7, register Rk captures the result at the clock edge, and every other register keeps its value.
- R5: With load low, no register changes.
- R6: Destination code 0 writes no register, even with load high.
- R7: When a source and the destination name the same register, the operation uses the old value. The new value is visible from the next cycle onward.
- R8: Op 1 computes A+B and op 2 computes A-B (as A + ~B + 1). C is the carry out of the 8-bit sum, so for subtract C=1 means no borrow. V flags two's-complement overflow.
- R9: Op 3 computes A+1 and op 4 computes A-1 (as A + 0xFF). C is the carry out, and V flags signed overflow.
- R10: Op 0 passes A, op 5 is AND, op 6 is OR, op 7 is XOR and op 8 is the complement of A. All of these give C=0 and V=0.
- R11: Op 9 shifts A left by one place, and op 10 shifts A right by one place (logical shift). In both cases C receives the bit shifted out and V=0.
- R12: Z is 1 exactly when the result is zero, and N equals the result's bit 7. Op codes 11 to 15 give result 0 with C=0 and V=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 8 | External input word, used as an operand when a select is 0 |
| sel_a | input | 3 | Operand A select (0 = external input, k = Rk) |
| sel_b | input | 3 | Operand B select (0 = external input, k = Rk) |
| sel_d | input | 3 | Destination register (0 = none) |
| op | input | 4 | ALU operation code |
| ld | input | 1 | Load enable for the destination register |
| result | output | 8 | ALU result |
| flag_c | output | 1 | Carry / shifted-out bit |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_v | output | 1 | Signed overflow |

## Verification
The bench targets a destination code of 0 with load high. A decoder that treats code 0 as a register would overwrite one of the registers. It also drives a source that equals the destination. A design that forwarded the new value would show the incremented value twice. Arithmetic is driven across the signed and unsigned wrap points (0x7F+1, 0xFF+1, 0x80-1, 0x00-1) and through subtraction in both directions. This exposes an inverted carry convention for subtract or a wrong overflow term. The shifts are run with patterns that set and clear the shifted-out bit, which catches a carry taken from the wrong end.

// File: rtl/rdp_pkg.sv
// Package: shared opcode encoding and status-flag type for the register datapath.
// Assumes a 4-bit operation field; codes 11..15 are unassigned.
package rdp_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NOT  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10
    } rdp_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } rdp_flags_t;

endpackage

// File: rtl/rdp_dest_decoder.sv
// Module: destination decoder. Turns the destination code into a one-hot
// write-enable vector qualified by the load signal.
// Assumes code 0 means "no register"; codes 1..NREG map to enable bits 0..NREG-1.
module rdp_dest_decoder #(
    parameter int NREG = 7,
    localparam int SEL_W = $clog2(NREG + 1)
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             ld,
    output logic [NREG-1:0]  we
);

    // One comparator per register: enable only that register's own code.
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign we[i] = ld && (sel == SEL_W'(i + 1));
    end

endmodule

// File: rtl/rdp_regfile.sv
// Module: register file of NREG words with one-hot write enables.
// Assumes at most one enable is high per cycle; a synchronous active-low reset
// clears every register and takes priority over writes.
module rdp_regfile #(
    parameter int W    = 8,
    parameter int NREG = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          we,
    input  logic [W-1:0]             wdata,
    output logic [NREG-1:0][W-1:0]   regs
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold, clear on reset, or capture the write data when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we[i]) begin
                regs[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rdp_operand_mux.sv
// Module: operand multiplexer. Select 0 picks the external word; select k
// picks register k (stored at index k-1).
// Assumes select codes above NREG never occur; they would also give the external word.
module rdp_operand_mux #(
    parameter int W    = 8,
    parameter int NREG = 7,
    localparam int SEL_W = $clog2(NREG + 1)
) (
    input  logic [SEL_W-1:0]         sel,
    input  logic [W-1:0]             ext,
    input  logic [NREG-1:0][W-1:0]   regs,
    output logic [W-1:0]             operand
);

    // Priority-free select: only one code can match.
    always_comb begin
        operand = ext;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                operand = regs[i];
            end
        end
    end

endmodule

// File: rtl/rdp_alu.sv
// Module: combinational ALU with carry, zero, negative and overflow flags.
// Assumes two's-complement operands; subtract sets C as "no borrow".
module rdp_alu
    import rdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    res,
    output rdp_flags_t      flags
);

    localparam int MSB = W - 1;
    localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

    logic [W:0] sum;
    logic       carry;
    logic       ovf;

    // Operation select; carry and overflow are set per operation class.
    always_comb begin
        sum   = '0;
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        case (rdp_op_e'(op))
            OP_PASS: res = a;
            OP_ADD: begin
                sum   = {1'b0, a} + {1'b0, b};
                res   = sum[W-1:0];
                carry = sum[W];
                ovf   = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB: begin
                sum   = {1'b0, a} + {1'b0, ~b} + ONE_X;
                res   = sum[W-1:0];
                carry = sum[W];
                ovf   = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_INC: begin
                sum   = {1'b0, a} + ONE_X;
                res   = sum[W-1:0];
                carry = sum[W];
                ovf   = !a[MSB] && res[MSB];
            end
            OP_DEC: begin
                sum   = {1'b0, a} + {1'b0, {W{1'b1}}};
                res   = sum[W-1:0];
                carry = sum[W];
                ovf   = a[MSB] && !res[MSB];
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res   = {a[W-2:0], 1'b0};
                carry = a[MSB];
            end
            OP_SHR: begin
                res   = {1'b0, a[W-1:1]};
                carry = a[0];
            end
            default: res = '0;
        endcase
    end

    // Flag packing: Z and N derive from the result for every operation.
    always_comb begin
        flags.c = carry;
        flags.z = (res == '0);
        flags.n = res[MSB];
        flags.v = ovf;
    end

endmodule

// File: rtl/gp_reg_datapath.sv
// Module: general register datapath top. One micro-operation per clock:
// two operands are selected, the ALU computes, and the destination register
// captures the result when load is high and the destination code is nonzero.
// Assumes the controller holds inputs stable around the rising edge.
module gp_reg_datapath
    import rdp_pkg::*;
#(
    parameter int W    = 8,
    parameter int NREG = 7,
    localparam int SEL_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      ext_in,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    input  logic [SEL_W-1:0]  sel_d,
    input  logic [OP_W-1:0]   op,
    input  logic              ld,
    output logic [W-1:0]      result,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v
);

    logic [NREG-1:0][W-1:0] regs;
    logic [NREG-1:0]        we;
    logic [W-1:0]           bus_a;
    logic [W-1:0]           bus_b;
    rdp_flags_t             flags;

    rdp_dest_decoder #(.NREG(NREG)) u_dec (
        .sel (sel_d),
        .ld  (ld),
        .we  (we)
    );

    rdp_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wdata (result),
        .regs  (regs)
    );

    rdp_operand_mux #(.W(W), .NREG(NREG)) u_mux_a (
        .sel     (sel_a),
        .ext     (ext_in),
        .regs    (regs),
        .operand (bus_a)
    );

    rdp_operand_mux #(.W(W), .NREG(NREG)) u_mux_b (
        .sel     (sel_b),
        .ext     (ext_in),
        .regs    (regs),
        .operand (bus_b)
    );

    rdp_alu #(.W(W)) u_alu (
        .a     (bus_a),
        .b     (bus_b),
        .op    (op),
        .res   (result),
        .flags (flags)
    );

    // Flag outputs: unpack the ALU status struct onto the ports.
    always_comb begin
        flag_c = flags.c;
        flag_z = flags.z;
        flag_n = flags.n;
        flag_v = flags.v;
    end

endmodule

// File: rtl/rdp_checker.sv
// Module: property checker for the register datapath, bound to the top.
// Observes ports only; register contents are inferred via pass-through reads.
module rdp_checker
    import rdp_pkg::*;
#(
    parameter int W    = 8,
    parameter int NREG = 7,
    localparam int SEL_W = $clog2(NREG + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      ext_in,
    input logic [SEL_W-1:0]  sel_a,
    input logic [SEL_W-1:0]  sel_b,
    input logic [SEL_W-1:0]  sel_d,
    input logic [OP_W-1:0]   op,
    input logic              ld,
    input logic [W-1:0]      result,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_n,
    input logic              flag_v
);

    a_r2_ext_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PASS && sel_a == '0) |-> (result == ext_in));

    a_r3_ext_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD && sel_a == '0 && sel_b == '0) |-> (result == W'(ext_in + ext_in)));

    a_r4_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && sel_d != '0) |=>
        (!(op == OP_PASS && sel_a == $past(sel_d)) || result == $past(result)));

    a_r5_no_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && op == OP_PASS && sel_a != '0) |=>
        (!(op == OP_PASS && sel_a == $past(sel_a)) || result == $past(result)));

    a_r6_dest_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && sel_d == '0 && op == OP_PASS && sel_a != '0) |=>
        (!(op == OP_PASS && sel_a == $past(sel_a)) || result == $past(result)));

    a_r10_logic_no_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOT || op == OP_PASS)
        |-> (!flag_c && !flag_v));

    a_r12_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z == (result == '0));

    a_r12_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_n == result[W-1]);

endmodule

bind gp_reg_datapath rdp_checker #(.W(W), .NREG(NREG)) u_chk (.*);

// File: tb/gp_reg_datapath_tb.sv
module gp_reg_datapath_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ext_in = '0;
    logic [2:0] sel_a = '0;
    logic [2:0] sel_b = '0;
    logic [2:0] sel_d = '0;
    logic [3:0] op = '0;
    logic       ld = 1'b0;
    logic [7:0] result;
    logic       flag_c, flag_z, flag_n, flag_v;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gp_reg_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .sel_a(sel_a), .sel_b(sel_b),
        .sel_d(sel_d), .op(op), .ld(ld), .result(result),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] k, input logic [7:0] val);
        @(negedge clk);
        sel_a = 3'd0; ext_in = val; op = 4'd0; sel_d = k; ld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld = 1'b0; sel_d = 3'd0;
    endtask

    task automatic read_reg(input logic [2:0] k, output logic [7:0] val);
        @(negedge clk);
        ld = 1'b0; sel_a = k; op = 4'd0;
        #1 val = result;
    endtask

    // R1: reset clears all, load during reset ignored
    task automatic t_reset();
        logic [7:0] v;
        rst_n = 1'b0; ld = 1'b1; sel_d = 3'd3; ext_in = 8'h55;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ld = 1'b0; sel_d = 3'd0; rst_n = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            read_reg(3'(k), v);
            chk(v == 8'h00, "R1 reset value", v, 0);
        end
    endtask

    // R2/R4: load each register, read through mux A; external on A
    task automatic t_load_and_read_a();
        logic [7:0] v;
        for (int k = 1; k <= 7; k++) write_reg(3'(k), 8'(8'h11 * k));
        for (int k = 1; k <= 7; k++) begin
            read_reg(3'(k), v);
            chk(v == 8'(8'h11 * k), "R2/R4 register via A", v, 8'(8'h11 * k));
        end
        @(negedge clk);
        sel_a = 3'd0; op = 4'd0; ext_in = 8'hA7;
        #1 chk(result == 8'hA7, "R2 external on A", result, 8'hA7);
    endtask

    // R4: writing one register leaves the others unchanged
    task automatic t_single_target();
        logic [7:0] v;
        write_reg(3'd5, 8'hE1);
        for (int k = 1; k <= 7; k++) begin
            read_reg(3'(k), v);
            if (k == 5) chk(v == 8'hE1, "R4 target written", v, 8'hE1);
            else chk(v == 8'(8'h11 * k), "R4 others kept", v, 8'(8'h11 * k));
        end
        write_reg(3'd5, 8'h55);
    endtask

    // R3: operand B selection (A = external 0, ADD)
    task automatic t_mux_b();
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            sel_a = 3'd0; ext_in = 8'h00; sel_b = 3'(k); op = 4'd1; ld = 1'b0;
            #1 chk(result == 8'(8'h11 * k), "R3 register via B", result, 8'(8'h11 * k));
        end
        @(negedge clk);
        sel_a = 3'd0; sel_b = 3'd0; ext_in = 8'h3C; op = 4'd1;
        #1 chk(result == 8'h78, "R3 external on B", result, 8'h78);
        sel_b = 3'd0;
    endtask

    // R5: load low writes nothing
    task automatic t_no_load();
        logic [7:0] v;
        @(negedge clk);
        sel_a = 3'd0; ext_in = 8'hFF; op = 4'd0; sel_d = 3'd2; ld = 1'b0;
        @(posedge clk);
        read_reg(3'd2, v);
        chk(v == 8'h22, "R5 no write without load", v, 8'h22);
        sel_d = 3'd0;
    endtask

    // R6: destination 0 writes nothing
    task automatic t_dest_zero();
        logic [7:0] v;
        @(negedge clk);
        sel_a = 3'd0; ext_in = 8'hAA; op = 4'd0; sel_d = 3'd0; ld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            read_reg(3'(k), v);
            chk(v == 8'(8'h11 * k), "R6 dest 0 writes nothing", v, 8'(8'h11 * k));
        end
    endtask

    // R7: same source and destination
    task automatic t_same_reg();
        logic [7:0] v;
        @(negedge clk);
        sel_a = 3'd3; op = 4'd3; sel_d = 3'd3; ld = 1'b1;
        #1 chk(result == 8'h34, "R7 old value used", result, 8'h34);
        @(posedge clk);
        @(negedge clk);
        #1 chk(result == 8'h35, "R7 new value next cycle", result, 8'h35);
        @(posedge clk);
        @(negedge clk);
        ld = 1'b0; sel_d = 3'd0;
        read_reg(3'd3, v);
        chk(v == 8'h35, "R7 final register", v, 8'h35);
    endtask

    // ALU case: A from external, B from R7
    task automatic alu_case(input string req, input logic [3:0] code, input logic [7:0] a,
                            input logic [7:0] b, input logic [7:0] er, input logic [3:0] ef);
        write_reg(3'd7, b);
        @(negedge clk);
        sel_a = 3'd0; ext_in = a; sel_b = 3'd7; op = code; ld = 1'b0; sel_d = 3'd0;
        #1;
        chk(result == er, req, result, er);
        chk({flag_c, flag_z, flag_n, flag_v} == ef, req, {flag_c, flag_z, flag_n, flag_v}, ef);
    endtask

    // flags order {C,Z,N,V}
    task automatic t_arith();
        alu_case("R8 add signed ovf", 4'd1, 8'h7F, 8'h01, 8'h80, 4'b0011);
        alu_case("R8 add wrap",       4'd1, 8'hFF, 8'h01, 8'h00, 4'b1100);
        alu_case("R8 sub no borrow",  4'd2, 8'hF0, 8'h14, 8'hDC, 4'b1010);
        alu_case("R8 sub borrow",     4'd2, 8'h14, 8'hF0, 8'h24, 4'b0000);
        alu_case("R8 sub signed ovf", 4'd2, 8'h80, 8'h01, 8'h7F, 4'b1001);
        alu_case("R8 sub equal",      4'd2, 8'h42, 8'h42, 8'h00, 4'b1100);
        alu_case("R9 inc ovf",        4'd3, 8'h7F, 8'h00, 8'h80, 4'b0011);
        alu_case("R9 inc wrap",       4'd3, 8'hFF, 8'h00, 8'h00, 4'b1100);
        alu_case("R9 dec from zero",  4'd4, 8'h00, 8'h00, 8'hFF, 4'b0010);
        alu_case("R9 dec ovf",        4'd4, 8'h80, 8'h00, 8'h7F, 4'b1001);
        alu_case("R9 dec to zero",    4'd4, 8'h01, 8'h00, 8'h00, 4'b1100);
    endtask

    task automatic t_logic_shift();
        alu_case("R10 and",        4'd5, 8'hF0, 8'h3C, 8'h30, 4'b0000);
        alu_case("R10 and zero",   4'd5, 8'h0F, 8'hF0, 8'h00, 4'b0100);
        alu_case("R10 or",         4'd6, 8'hF0, 8'h3C, 8'hFC, 4'b0010);
        alu_case("R10 xor",        4'd7, 8'hF0, 8'h3C, 8'hCC, 4'b0010);
        alu_case("R10 not",        4'd8, 8'h5A, 8'hFF, 8'hA5, 4'b0010);
        alu_case("R10 pass zero",  4'd0, 8'h00, 8'hFF, 8'h00, 4'b0100);
        alu_case("R11 shl carry",  4'd9, 8'h81, 8'h00, 8'h02, 4'b1000);
        alu_case("R11 shl neg",    4'd9, 8'h40, 8'h00, 8'h80, 4'b0010);
        alu_case("R11 shr carry",  4'd10, 8'h81, 8'h00, 8'h40, 4'b1000);
        alu_case("R11 shr to zero", 4'd10, 8'h01, 8'h00, 8'h00, 4'b1100);
        alu_case("R12 unused op",  4'd15, 8'h55, 8'hAA, 8'h00, 4'b0100);
        alu_case("R12 unused op11", 4'd11, 8'hFF, 8'hFF, 8'h00, 4'b0100);
    endtask

    initial begin
        t_reset();
        t_load_and_read_a();
        t_single_target();
        t_mux_b();
        t_no_load();
        t_dest_zero();
        t_same_reg();
        t_arith();
        t_logic_shift();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule